// File: doc/BRIEF.md
# Oscillator Configuration Request Dispatcher

This block is a small memory-mapped configuration controller that lets software reach a table of programmable oscillator registers through three bus words. Software first places a 32-bit value in the data word. It then writes a packed control word that names a target by five address fields, picks the direction and carries a start flag. On a started request the block looks up the target among its oscillators. It then copies that oscillator's frequency in Hz into the data word, or it programs the oscillator with the value in the data word.

Every oscillator comes out of reset at a fixed default frequency. A status word records that a started request has finished, and whether it failed. A request fails when the target is unknown or when software tries to program a frequency of zero. A request that fails changes no oscillator and leaves the data word as it was.

The register bus is plain: address, write enable, write data and a read data path that follows the address in the same cycle. It has no back-pressure. A started request always completes in the cycle after the control write, so the bus never has to wait.

Top module: `cfg_osc_dispatch`

## Requirements
- R1: Reset clears the data word, the control word and the status word to zero. It also restores every oscillator to its default frequency.
- R2: A control write with bit 31 (start) clear starts no transfer. The data word keeps its value and the status stays zero.
- R3: A started control write with bit 30 clear copies the addressed oscillator's frequency into the data word on the following clock edge. On that same edge status bit 0 (done) is set.
- R4: A started control write with bit 30 set stores the data word into the addressed oscillator, provided the data word is non-zero. A later read request returns the new value.
- R5: A target is matched on control bits 29:0 only. These bits hold device 11:0, position 15:12, site 17:16, the unused bits 19:18, function 25:20 and the dcc field 29:26. A request with any other value in these bits does not match the oscillator.
- R6: A started request that matches no oscillator leaves the data word and all oscillators unchanged. It sets both status bit 0 (done) and status bit 1 (error).
- R7: A started write of the value zero is rejected. The oscillator keeps its old frequency and status reads 3 (done and error).
- R8: Any write to the control word clears both status bits in the same edge that captures the control word.
- R9: Word offset 0 is the data word and offset 1 is the control word; both are readable and writable. Offset 2 is the status word, which is read-only, so writes to it are ignored. Offset 3 reads as zero.
- R10: Every oscillator has function code 1, dcc 0 and position 0. At site 0 the defaults are device 0 = 25000000, device 1 = 25000000 and device 2 = 24000000. At site 1 they are device 0 = 50000000, device 4 = 40000000, device 5 = 50000000, device 6 = 35000000, device 7 = 40000000 and device 8 = 40000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Word offset of the register access |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
On every cycle, the assertions check several timing rules. The done and error flags rise only one edge after a started control write. A control write always clears both flags. The data word holds still when no transfer and no data write are under way. The unused offset always reads zero.

Other behaviour can only be shown by the bench's scenarios. These include the default frequency of each oscillator, a programmed frequency that survives until it is read back, and the rejection of a zero write. They also include the exact field match that turns bits 19:18 or a wrong site into an unknown target.

// File: rtl/cfg_osc_pkg.sv
package cfg_osc_pkg;

  localparam int WORD_W    = 32;
  localparam int KEY_W     = 30;
  localparam int BIT_START = 31;
  localparam int BIT_WR    = 30;

  localparam int DEV_LSB  = 0;
  localparam int POS_LSB  = 12;
  localparam int SITE_LSB = 16;
  localparam int FUNC_LSB = 20;
  localparam int DCC_LSB  = 26;

  localparam int FUNC_OSC = 1;

  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_CTRL = 2'd1;
  localparam logic [1:0] OFF_STAT = 2'd2;

  localparam int DEFAULT_OSC_COUNT = 9;

  // Assemble the 30-bit target key from its fields.
  function automatic logic [KEY_W-1:0] make_key(input int dcc, input int fn,
                                                input int site, input int pos,
                                                input int dev);
    logic [KEY_W-1:0] k;
    k = '0;
    k[DEV_LSB  +: 12] = dev[11:0];
    k[POS_LSB  +: 4]  = pos[3:0];
    k[SITE_LSB +: 2]  = site[1:0];
    k[FUNC_LSB +: 6]  = fn[5:0];
    k[DCC_LSB  +: 4]  = dcc[3:0];
    return k;
  endfunction

  function automatic int osc_site(input int idx);
    return (idx < 3) ? 0 : 1;
  endfunction

  function automatic int osc_dev(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 0;
      4: return 4;
      5: return 5;
      6: return 6;
      7: return 7;
      8: return 8;
      default: return 4095;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] osc_reset_hz(input int idx);
    case (idx)
      0, 1:    return 32'd25_000_000;
      2:       return 32'd24_000_000;
      3, 5:    return 32'd50_000_000;
      6:       return 32'd35_000_000;
      4, 7, 8: return 32'd40_000_000;
      default: return 32'd1_000_000;
    endcase
  endfunction

endpackage

// File: rtl/cfg_word_split.sv
module cfg_word_split
  import cfg_osc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              start,
  output logic              is_write,
  output logic [KEY_W-1:0]  key
);
  assign start    = word[BIT_START];
  assign is_write = word[BIT_WR];
  assign key      = word[KEY_W-1:0];
endmodule

// File: rtl/osc_bank.sv
module osc_bank
  import cfg_osc_pkg::*;
#(
  parameter int N_OSC = DEFAULT_OSC_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  key,
  input  logic              go,
  input  logic              is_write,
  input  logic [WORD_W-1:0] wr_hz,
  output logic              hit,
  output logic              zero_reject,
  output logic [WORD_W-1:0] rd_hz
);
  logic [N_OSC-1:0]  match;
  logic [WORD_W-1:0] hz_q [N_OSC];
  logic              wr_ok;

  assign wr_ok = go && is_write && (wr_hz != '0);

  for (genvar i = 0; i < N_OSC; i++) begin : g_osc
    localparam logic [KEY_W-1:0] MY_KEY =
      make_key(0, FUNC_OSC, osc_site(i), 0, osc_dev(i));
    localparam logic [WORD_W-1:0] MY_RST = osc_reset_hz(i);

    assign match[i] = (key == MY_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  hz_q[i] <= MY_RST;
      else if (wr_ok && match[i])  hz_q[i] <= wr_hz;
    end
  end

  assign hit         = |match;
  assign zero_reject = go && is_write && (wr_hz == '0);

  always_comb begin
    rd_hz = '0;
    for (int j = 0; j < N_OSC; j++) begin
      if (match[j]) rd_hz = rd_hz | hz_q[j];
    end
  end
endmodule

// File: rtl/cfg_status.sv
module cfg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_done,
  input  logic set_err,
  output logic done,
  output logic err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else if (clr) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (set_done) done <= 1'b1;
      if (set_err)  err  <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_osc_dispatch.sv
module cfg_osc_dispatch
  import cfg_osc_pkg::*;
#(
  parameter int N_OSC  = DEFAULT_OSC_COUNT,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  logic [WORD_W-1:0] data_q;
  logic [WORD_W-1:0] ctrl_q;
  logic              go_q;
  logic              stat_done;
  logic              stat_err;

  logic              data_sel;
  logic              ctrl_sel;
  logic              req_start;
  logic              req_wr;
  logic [KEY_W-1:0]  req_key;
  logic              hit;
  logic              zero_reject;
  logic [WORD_W-1:0] rd_hz;

  assign data_sel = bus_we && (bus_addr == ADDR_W'(OFF_DATA));
  assign ctrl_sel = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));

  cfg_word_split u_split (
    .word     (ctrl_q),
    .start    (req_start),
    .is_write (req_wr),
    .key      (req_key)
  );

  // The transfer runs one edge after the started control write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      go_q   <= 1'b0;
    end else begin
      go_q <= ctrl_sel && bus_wdata[BIT_START];
      if (ctrl_sel) ctrl_q <= bus_wdata;
    end
  end

  osc_bank #(.N_OSC(N_OSC)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .key         (req_key),
    .go          (go_q && req_start && hit),
    .is_write    (req_wr),
    .wr_hz       (data_q),
    .hit         (hit),
    .zero_reject (zero_reject),
    .rd_hz       (rd_hz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        data_q <= '0;
    else if (go_q && hit && !req_wr)   data_q <= rd_hz;
    else if (data_sel)                 data_q <= bus_wdata;
  end

  cfg_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ctrl_sel),
    .set_done (go_q),
    .set_err  (go_q && (!hit || zero_reject)),
    .done     (stat_done),
    .err      (stat_err)
  );

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_DATA): bus_rdata = data_q;
      ADDR_W'(OFF_CTRL): bus_rdata = ctrl_q;
      ADDR_W'(OFF_STAT): bus_rdata = {30'd0, stat_err, stat_done};
      default:           bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_osc_dispatch_chk.sv
module cfg_osc_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        go_q,
  input logic        stat_done,
  input logic        stat_err
);
  logic ctrl_wr;
  logic data_wr;
  logic [31:0] data_view;
  assign ctrl_wr = bus_we && (bus_addr == 2'd1);
  assign data_wr = bus_we && (bus_addr == 2'd0);
  assign data_view = (bus_addr == 2'd0) ? bus_rdata : 32'd0;

  // R2: no transfer follows a control write without start
  a_r2_no_start_no_go: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[31]) |=> !go_q);

  // R3: done is set one edge after a started request
  a_r3_done_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !ctrl_wr) |=> stat_done);

  // R3: done never rises without a pending request
  a_r3_done_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_done) |-> $past(go_q));

  // R6: error never rises without a pending request
  a_r6_err_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_err) |-> $past(go_q));

  // R8: control write clears both flags
  a_r8_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (!stat_done && !stat_err));

  // R2: data word holds while idle (observed when offset 0 is addressed)
  a_r2_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_q && !data_wr && bus_addr == 2'd0) ##1 (bus_addr == 2'd0)
      |-> (data_view == $past(data_view)));

  // R9: unused offset reads zero
  a_r9_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == 32'd0));
endmodule

bind cfg_osc_dispatch cfg_osc_dispatch_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .go_q      (go_q),
  .stat_done (stat_done),
  .stat_err  (stat_err)
);

// File: tb/sim_cfg_osc_dispatch.sv
module sim_cfg_osc_dispatch;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q [$];
  logic [1:0]  adr_q [$];
  string       tag_q [$];

  always #(CLK_PER/2) clk = ~clk;

  cfg_osc_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Expected oscillator table: site, device, frequency
  int          t_site [9] = '{0, 0, 0, 1, 1, 1, 1, 1, 1};
  int          t_dev  [9] = '{0, 1, 2, 0, 4, 5, 6, 7, 8};
  logic [31:0] t_hz   [9] = '{32'd25000000, 32'd25000000, 32'd24000000,
                              32'd50000000, 32'd40000000, 32'd50000000,
                              32'd35000000, 32'd40000000, 32'd40000000};

  function automatic logic [31:0] cw(input bit st, input bit wr, input int dcc,
                                     input int fn, input int site,
                                     input int pos, input int dev);
    logic [31:0] w;
    w = 32'd0;
    w[31] = st; w[30] = wr;
    w[29:26] = dcc[3:0]; w[25:20] = fn[5:0];
    w[17:16] = site[1:0]; w[15:12] = pos[3:0]; w[11:0] = dev[11:0];
    return w;
  endfunction

  // Monitor: compares every queued item a quarter period after the negedge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PER/4);
      while (exp_q.size() > 0) begin
        logic [31:0] e;
        logic [1:0]  a;
        string       t;
        e = exp_q.pop_front();
        a = adr_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s offset=%0d actual=%h expected=%h", t, a, bus_rdata, e);
        end
      end
    end
  end

  task automatic expect_rd(input logic [1:0] a, input logic [31:0] v, input string t);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(v); adr_q.push_back(a); tag_q.push_back(t);
    @(posedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic request(input logic [31:0] w);
    bus_wr(2'd1, w);
    @(posedge clk);
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_rd(2'd0, 32'd0, "R1 data");
    expect_rd(2'd1, 32'd0, "R1 ctrl");
    expect_rd(2'd2, 32'd0, "R1 status");

    // R10 / R3 default frequencies via read requests
    for (int i = 0; i < 9; i++) begin
      request(cw(1, 0, 0, 1, t_site[i], 0, t_dev[i]));
      expect_rd(2'd0, t_hz[i], "R10 default freq");
      expect_rd(2'd2, 32'd1, "R3 done");
    end

    // R2 no start: data kept, status zero, control word readable (R9)
    bus_wr(2'd0, 32'h0000_1234);
    request(cw(0, 0, 0, 1, 1, 0, 4));
    expect_rd(2'd0, 32'h0000_1234, "R2 data kept");
    expect_rd(2'd2, 32'd0, "R2 status");
    expect_rd(2'd1, cw(0, 0, 0, 1, 1, 0, 4), "R9 ctrl readback");

    // R4 program site1 dev4, read back
    bus_wr(2'd0, 32'd12345678);
    request(cw(1, 1, 0, 1, 1, 0, 4));
    expect_rd(2'd2, 32'd1, "R4 write done");
    bus_wr(2'd0, 32'd0);
    request(cw(1, 0, 0, 1, 1, 0, 4));
    expect_rd(2'd0, 32'd12345678, "R4 readback");

    // R6 unknown device: site1 dev3
    bus_wr(2'd0, 32'h0000_AAAA);
    request(cw(1, 0, 0, 1, 1, 0, 3));
    expect_rd(2'd0, 32'h0000_AAAA, "R6 data unchanged");
    expect_rd(2'd2, 32'd3, "R6 error");

    // R5 bits 19:18 break the match; wrong function too
    request(cw(1, 0, 0, 1, 0, 0, 0) | 32'h0004_0000);
    expect_rd(2'd0, 32'h0000_AAAA, "R5 data unchanged");
    expect_rd(2'd2, 32'd3, "R5 error bits19_18");
    request(cw(1, 1, 0, 2, 0, 0, 0));
    expect_rd(2'd2, 32'd3, "R5 error wrong func");
    request(cw(1, 0, 0, 1, 0, 0, 0));
    expect_rd(2'd0, 32'd25000000, "R5 site0 dev0 intact");

    // R7 zero write rejected
    bus_wr(2'd0, 32'd0);
    request(cw(1, 1, 0, 1, 0, 0, 2));
    expect_rd(2'd2, 32'd3, "R7 error");
    request(cw(1, 0, 0, 1, 0, 0, 2));
    expect_rd(2'd0, 32'd24000000, "R7 freq kept");

    // R8 clear via non-start control write after error
    request(cw(1, 0, 0, 1, 3, 0, 0));
    expect_rd(2'd2, 32'd3, "R8 error set");
    bus_wr(2'd1, 32'd0);
    expect_rd(2'd2, 32'd0, "R8 cleared");

    // R9 status read-only, hole reads zero
    request(cw(1, 0, 0, 1, 1, 0, 8));
    bus_wr(2'd2, 32'hFFFF_FFFF);
    expect_rd(2'd2, 32'd1, "R9 status read-only");
    bus_wr(2'd3, 32'h5555_5555);
    expect_rd(2'd3, 32'd0, "R9 hole");
    expect_rd(2'd0, 32'd40000000, "R9 data intact");

    // R1 reset restores programmed oscillator
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_rd(2'd2, 32'd0, "R1 status after reset");
    request(cw(1, 0, 0, 1, 1, 0, 4));
    expect_rd(2'd0, 32'd40000000, "R1 default restored");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule